// File: doc/BRIEF.md
# Six-Valued Hazard-Aware Gate Evaluator

This block evaluates one logic gate across a lane of parallel patterns in a six-valued signal algebra. A signal is static low, static high, a rising edge, a falling edge, a glitch that pulses high, or a glitch that pulses low. Every signal is carried as three bit-planes: the value after settling, the value before the transition, and a flag that marks any transition or pulse. Each plane is a vector with one bit per lane, so all lanes are evaluated in the same cycle with a shared opcode.

The gate is picked by an opcode. The set covers a buffer and an inverter, AND, NAND, OR and NOR with two, three or four operands, and two-operand XOR and XNOR. The hazard flag does not follow plain Boolean rules. A transition on one operand only reaches the output while every other operand stays away from the gate's static controlling value. The result is registered with one cycle of latency and carries a valid bit and an error bit that flags an unknown opcode.

Top module: `hz6_gate_eval`

## Requirements
- R1: A lane's value is the three-bit code {hazard, initial, final}, with static 0 = 000, static 1 = 011, low pulse P = 100, rise R = 101, fall F = 110 and high pulse N = 111. Bit 0 travels on the `*_fin` plane, bit 1 on `*_ini` and bit 2 on `*_hz`. The evaluator gives R AND F = P, R OR F = N, R XOR R = P, 1 XOR R = F and NOT P = N.
- R2: For AND, the result's final and initial planes are the AND of the active operands' planes. The hazard bit is 1 when an active operand has its hazard bit set and no other active operand is static 0 (000).
- R3: For OR, the result's final and initial planes are the OR of the active operands' planes. The hazard bit is 1 when an active operand has its hazard bit set and no other active operand is static 1 (011).
- R4: For XOR, the result's final and initial planes are the XOR of operands 0 and 1, and its hazard plane is the OR of their hazard planes.
- R5: BUF copies operand 0. INV, NAND, NOR and XNOR take the result of the matching non-inverting gate and complement its final and initial planes. The hazard plane stays as it was.
- R6: The opcodes are 0 BUF, 1 INV, 2/3/4 AND with 2/3/4 operands, 5/6/7 NAND with 2/3/4, 8/9/10 OR with 2/3/4, 11/12/13 NOR with 2/3/4, 14 XOR and 15 XNOR. A gate uses operands 0 up to its arity minus one, and the other operand slots have no effect on the result.
- R7: A result appears one clock after its inputs are accepted. `out_vld` equals `in_vld` from the cycle before.
- R8: An opcode from 16 to 31 that arrives with `in_vld` high produces static 0 in every lane, with `out_err` high for that one result.
- R9: A synchronous active-high reset clears `out_vld`, `out_err` and all result planes.
- R10: Each lane is evaluated on its own data. A result lane depends only on the same lane of the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operands and opcode are valid this cycle |
| op | input | 5 | Gate opcode |
| opd_fin | input | 4 x LANES | Final-value plane of operands 0..3 |
| opd_ini | input | 4 x LANES | Initial-value plane of operands 0..3 |
| opd_hz | input | 4 x LANES | Hazard plane of operands 0..3 |
| out_vld | output | 1 | Result valid |
| out_err | output | 1 | Result came from an unknown opcode |
| res_fin | output | LANES | Final-value plane of the result |
| res_ini | output | LANES | Initial-value plane of the result |
| res_hz | output | LANES | Hazard plane of the result |

## Verification
The bench runs all 36 operand pairs on every two-operand gate. Random codes always fill the unused operand slots, so a decoder with a wrong arity would let a stray static 0 or static 1 kill or force results. Random vectors for the three- and four-operand gates cover the case where one controlling static operand must suppress a hazard coming from another operand. A design that used plain Boolean OR for the hazard plane would report pulses where the result is in fact static. Directed vectors pin down the five named results, the complementing of inverting gates (a design that also flipped the hazard plane would turn P into 011), and the zero-and-error response to unknown opcodes. A design that let an unknown opcode fall through to BUF would echo operand 0.

// File: rtl/hz6_pkg.sv
package hz6_pkg;

    localparam int HZ6_OPW   = 5;
    localparam int HZ6_MAXIN = 4;
    localparam int HZ6_ARW   = $clog2(HZ6_MAXIN + 1);

    typedef enum logic [1:0] {
        FAM_BUF = 2'd0,
        FAM_AND = 2'd1,
        FAM_OR  = 2'd2,
        FAM_XOR = 2'd3
    } hz6_family_e;

    typedef struct packed {
        hz6_family_e              fam;
        logic [HZ6_ARW-1:0]       arity;
        logic                     invert;
        logic                     legal;
    } hz6_dec_t;

endpackage

// File: rtl/hz6_decode.sv
module hz6_decode
    import hz6_pkg::*;
(
    input  logic [HZ6_OPW-1:0] op_i,
    output hz6_dec_t           dec_o
);

    always_comb begin
        dec_o        = '0;
        dec_o.fam    = FAM_BUF;
        dec_o.legal  = 1'b1;
        case (op_i)
            5'd0:  begin dec_o.fam = FAM_BUF; dec_o.arity = 3'd1; end
            5'd1:  begin dec_o.fam = FAM_BUF; dec_o.arity = 3'd1; dec_o.invert = 1'b1; end
            5'd2:  begin dec_o.fam = FAM_AND; dec_o.arity = 3'd2; end
            5'd3:  begin dec_o.fam = FAM_AND; dec_o.arity = 3'd3; end
            5'd4:  begin dec_o.fam = FAM_AND; dec_o.arity = 3'd4; end
            5'd5:  begin dec_o.fam = FAM_AND; dec_o.arity = 3'd2; dec_o.invert = 1'b1; end
            5'd6:  begin dec_o.fam = FAM_AND; dec_o.arity = 3'd3; dec_o.invert = 1'b1; end
            5'd7:  begin dec_o.fam = FAM_AND; dec_o.arity = 3'd4; dec_o.invert = 1'b1; end
            5'd8:  begin dec_o.fam = FAM_OR;  dec_o.arity = 3'd2; end
            5'd9:  begin dec_o.fam = FAM_OR;  dec_o.arity = 3'd3; end
            5'd10: begin dec_o.fam = FAM_OR;  dec_o.arity = 3'd4; end
            5'd11: begin dec_o.fam = FAM_OR;  dec_o.arity = 3'd2; dec_o.invert = 1'b1; end
            5'd12: begin dec_o.fam = FAM_OR;  dec_o.arity = 3'd3; dec_o.invert = 1'b1; end
            5'd13: begin dec_o.fam = FAM_OR;  dec_o.arity = 3'd4; dec_o.invert = 1'b1; end
            5'd14: begin dec_o.fam = FAM_XOR; dec_o.arity = 3'd2; end
            5'd15: begin dec_o.fam = FAM_XOR; dec_o.arity = 3'd2; dec_o.invert = 1'b1; end
            default: begin dec_o.legal = 1'b0; dec_o.arity = 3'd0; end
        endcase
    end

endmodule

// File: rtl/hz6_andor_core.sv
module hz6_andor_core #(
    parameter int LANES = 32,
    parameter int NIN   = 4
) (
    input  logic [$clog2(NIN+1)-1:0]  arity_i,
    input  logic [NIN-1:0][LANES-1:0] fin_i,
    input  logic [NIN-1:0][LANES-1:0] ini_i,
    input  logic [NIN-1:0][LANES-1:0] hz_i,
    output logic [LANES-1:0]          and_fin_o,
    output logic [LANES-1:0]          and_ini_o,
    output logic [LANES-1:0]          and_hz_o,
    output logic [LANES-1:0]          or_fin_o,
    output logic [LANES-1:0]          or_ini_o,
    output logic [LANES-1:0]          or_hz_o
);

    localparam int AW = $clog2(NIN + 1);

    // Inactive slots are replaced by the identity value of each family:
    // static 1 for AND, static 0 for OR.
    logic [NIN-1:0][LANES-1:0] a_fin, a_ini, a_hz, not0;
    logic [NIN-1:0][LANES-1:0] o_fin, o_ini, o_hz, not1;

    for (genvar gi = 0; gi < NIN; gi++) begin : g_slot
        logic act;
        assign act         = (AW'(gi) < arity_i);
        assign a_fin[gi]   = act ? fin_i[gi] : '1;
        assign a_ini[gi]   = act ? ini_i[gi] : '1;
        assign a_hz[gi]    = act ? hz_i[gi]  : '0;
        assign o_fin[gi]   = act ? fin_i[gi] : '0;
        assign o_ini[gi]   = act ? ini_i[gi] : '0;
        assign o_hz[gi]    = act ? hz_i[gi]  : '0;
        assign not0[gi]    = a_fin[gi] | a_ini[gi] | a_hz[gi];
        assign not1[gi]    = ~o_fin[gi] | ~o_ini[gi] | o_hz[gi];
    end

    always_comb begin
        logic [LANES-1:0] others_and, others_or;
        and_fin_o = '1;
        and_ini_o = '1;
        and_hz_o  = '0;
        or_fin_o  = '0;
        or_ini_o  = '0;
        or_hz_o   = '0;
        for (int i = 0; i < NIN; i++) begin
            and_fin_o = and_fin_o & a_fin[i];
            and_ini_o = and_ini_o & a_ini[i];
            or_fin_o  = or_fin_o | o_fin[i];
            or_ini_o  = or_ini_o | o_ini[i];
            others_and = '1;
            others_or  = '1;
            for (int j = 0; j < NIN; j++) begin
                if (j != i) begin
                    others_and = others_and & not0[j];
                    others_or  = others_or & not1[j];
                end
            end
            and_hz_o = and_hz_o | (a_hz[i] & others_and);
            or_hz_o  = or_hz_o | (o_hz[i] & others_or);
        end
    end

    // Guards: a controlling static operand pins the output; no input hazard, no output hazard.
    always_comb begin
        logic [LANES-1:0] any_zero, any_one, any_ahz, any_ohz;
        any_zero = '0;
        any_one  = '0;
        any_ahz  = '0;
        any_ohz  = '0;
        for (int i = 0; i < NIN; i++) begin
            any_zero = any_zero | ~not0[i];
            any_one  = any_one | ~not1[i];
            any_ahz  = any_ahz | a_hz[i];
            any_ohz  = any_ohz | o_hz[i];
        end
        if (!$isunknown({fin_i, ini_i, hz_i, arity_i})) begin
            a_r2_and_static0: assert (((and_fin_o | and_ini_o | and_hz_o) & any_zero) == '0)
                else $error("static 0 operand did not force AND result to 0");
            a_r3_or_static1: assert (((~or_fin_o | ~or_ini_o | or_hz_o) & any_one) == '0)
                else $error("static 1 operand did not force OR result to 1");
            a_r2_and_quiet: assert ((and_hz_o & ~any_ahz) == '0)
                else $error("AND hazard without any operand hazard");
            a_r3_or_quiet: assert ((or_hz_o & ~any_ohz) == '0)
                else $error("OR hazard without any operand hazard");
        end
    end

endmodule

// File: rtl/hz6_xor_core.sv
module hz6_xor_core #(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] a_fin_i,
    input  logic [LANES-1:0] a_ini_i,
    input  logic [LANES-1:0] a_hz_i,
    input  logic [LANES-1:0] b_fin_i,
    input  logic [LANES-1:0] b_ini_i,
    input  logic [LANES-1:0] b_hz_i,
    output logic [LANES-1:0] fin_o,
    output logic [LANES-1:0] ini_o,
    output logic [LANES-1:0] hz_o
);

    always_comb begin
        fin_o = a_fin_i ^ b_fin_i;
        ini_o = a_ini_i ^ b_ini_i;
        hz_o  = a_hz_i | b_hz_i;
    end

    always_comb begin
        if (!$isunknown({a_hz_i, b_hz_i})) begin
            a_r4_xor_hazard_kept: assert (((a_hz_i | b_hz_i) & ~hz_o) == '0)
                else $error("XOR dropped an operand hazard");
        end
    end

endmodule

// File: rtl/hz6_gate_eval.sv
module hz6_gate_eval
    import hz6_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_vld,
    input  logic [HZ6_OPW-1:0]              op,
    input  logic [HZ6_MAXIN-1:0][LANES-1:0] opd_fin,
    input  logic [HZ6_MAXIN-1:0][LANES-1:0] opd_ini,
    input  logic [HZ6_MAXIN-1:0][LANES-1:0] opd_hz,
    output logic                            out_vld,
    output logic                            out_err,
    output logic [LANES-1:0]                res_fin,
    output logic [LANES-1:0]                res_ini,
    output logic [LANES-1:0]                res_hz
);

    typedef struct packed {
        logic             vld;
        logic             err;
        logic [LANES-1:0] fin;
        logic [LANES-1:0] ini;
        logic [LANES-1:0] hz;
    } stage_t;

    hz6_dec_t         dec;
    logic [LANES-1:0] and_fin, and_ini, and_hz, or_fin, or_ini, or_hz;
    logic [LANES-1:0] x_fin, x_ini, x_hz;
    stage_t           st_d, st_q;

    hz6_decode u_dec (
        .op_i  (op),
        .dec_o (dec)
    );

    hz6_andor_core #(.LANES(LANES), .NIN(HZ6_MAXIN)) u_andor (
        .arity_i   (dec.arity),
        .fin_i     (opd_fin),
        .ini_i     (opd_ini),
        .hz_i      (opd_hz),
        .and_fin_o (and_fin),
        .and_ini_o (and_ini),
        .and_hz_o  (and_hz),
        .or_fin_o  (or_fin),
        .or_ini_o  (or_ini),
        .or_hz_o   (or_hz)
    );

    hz6_xor_core #(.LANES(LANES)) u_xor (
        .a_fin_i (opd_fin[0]),
        .a_ini_i (opd_ini[0]),
        .a_hz_i  (opd_hz[0]),
        .b_fin_i (opd_fin[1]),
        .b_ini_i (opd_ini[1]),
        .b_hz_i  (opd_hz[1]),
        .fin_o   (x_fin),
        .ini_o   (x_ini),
        .hz_o    (x_hz)
    );

    always_comb begin
        st_d     = '0;
        st_d.vld = in_vld;
        st_d.err = in_vld & ~dec.legal;
        case (dec.fam)
            FAM_AND: begin st_d.fin = and_fin;    st_d.ini = and_ini;    st_d.hz = and_hz;    end
            FAM_OR:  begin st_d.fin = or_fin;     st_d.ini = or_ini;     st_d.hz = or_hz;     end
            FAM_XOR: begin st_d.fin = x_fin;      st_d.ini = x_ini;      st_d.hz = x_hz;      end
            default: begin st_d.fin = opd_fin[0]; st_d.ini = opd_ini[0]; st_d.hz = opd_hz[0]; end
        endcase
        if (dec.invert) begin
            st_d.fin = ~st_d.fin;
            st_d.ini = ~st_d.ini;
        end
        if (!dec.legal) begin
            st_d.fin = '0;
            st_d.ini = '0;
            st_d.hz  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.vld;
    assign out_err = st_q.err;
    assign res_fin = st_q.fin;
    assign res_ini = st_q.ini;
    assign res_hz  = st_q.hz;

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);
    a_r7_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);
    a_r8_err_zero_result: assert property (@(posedge clk) disable iff (rst)
        out_err |-> (res_fin == '0 && res_ini == '0 && res_hz == '0));
    a_r8_err_needs_valid: assert property (@(posedge clk) disable iff (rst)
        out_err |-> out_vld);

endmodule

// File: tb/sim_hz6_gate_eval.sv
module sim_hz6_gate_eval;

    localparam int LANES      = 32;
    localparam int CLK_PERIOD = 10;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic                      in_vld = 1'b0;
    logic [4:0]                op = '0;
    logic [3:0][LANES-1:0]     opd_fin = '0, opd_ini = '0, opd_hz = '0;
    logic                      out_vld, out_err;
    logic [LANES-1:0]          res_fin, res_ini, res_hz;

    int errors = 0;
    int checks = 0;

    typedef struct packed {
        logic             err;
        logic [LANES-1:0] hz;
        logic [LANES-1:0] ini;
        logic [LANES-1:0] fin;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    logic [2:0] stim [4][LANES];
    logic [2:0] codes [6] = '{3'b000, 3'b011, 3'b100, 3'b101, 3'b110, 3'b111};

    always #(CLK_PERIOD/2) clk = ~clk;

    hz6_gate_eval #(.LANES(LANES)) u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .op(op),
        .opd_fin(opd_fin), .opd_ini(opd_ini), .opd_hz(opd_hz),
        .out_vld(out_vld), .out_err(out_err),
        .res_fin(res_fin), .res_ini(res_ini), .res_hz(res_hz)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Reference per lane, written from the requirements (R2..R6, R8).
    function automatic logic [3:0] ref_lane(input logic [4:0] opc, input logic [2:0] c0, c1, c2, c3);
        logic [2:0] c [4];
        int  n;
        int  fam;      // 0 buf, 1 and, 2 or, 3 xor
        bit  inv;
        logic fin, ini, hz, ok;
        c[0] = c0; c[1] = c1; c[2] = c2; c[3] = c3;
        inv = 0;
        if (opc > 5'd15) return 4'b1000;
        if (opc <= 1) begin fam = 0; n = 1; inv = (opc == 1); end
        else if (opc <= 4)  begin fam = 1; n = opc;     end
        else if (opc <= 7)  begin fam = 1; n = opc - 3; inv = 1; end
        else if (opc <= 10) begin fam = 2; n = opc - 6; end
        else if (opc <= 13) begin fam = 2; n = opc - 9; inv = 1; end
        else begin fam = 3; n = 2; inv = (opc == 15); end
        fin = c[0][0]; ini = c[0][1]; hz = c[0][2];
        if (fam == 1 || fam == 2) begin
            fin = (fam == 1); ini = (fam == 1); hz = 0;
            for (int i = 0; i < n; i++) begin
                if (fam == 1) begin fin &= c[i][0]; ini &= c[i][1]; end
                else          begin fin |= c[i][0]; ini |= c[i][1]; end
                if (c[i][2]) begin
                    ok = 1;
                    for (int j = 0; j < n; j++)
                        if (j != i && c[j] == ((fam == 1) ? 3'b000 : 3'b011)) ok = 0;
                    hz |= ok;
                end
            end
        end else if (fam == 3) begin
            fin = c[0][0] ^ c[1][0]; ini = c[0][1] ^ c[1][1]; hz = c[0][2] | c[1][2];
        end
        if (inv) begin fin = ~fin; ini = ~ini; end
        return {1'b0, hz, ini, fin};
    endfunction

    task automatic apply(input logic [4:0] opc, input string tag, input bit use_lit, input logic [2:0] lit);
        exp_t e;
        logic [3:0] r;
        @(negedge clk);
        op = opc;
        in_vld = 1'b1;
        e = '0;
        for (int l = 0; l < LANES; l++) begin
            for (int i = 0; i < 4; i++) begin
                opd_fin[i][l] = stim[i][l][0];
                opd_ini[i][l] = stim[i][l][1];
                opd_hz[i][l]  = stim[i][l][2];
            end
            r = ref_lane(opc, stim[0][l], stim[1][l], stim[2][l], stim[3][l]);
            if (use_lit) r = {1'b0, lit};
            e.fin[l] = r[0]; e.ini[l] = r[1]; e.hz[l] = r[2]; e.err = r[3];
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    task automatic fill_random();
        for (int l = 0; l < LANES; l++)
            for (int i = 0; i < 4; i++) stim[i][l] = codes[$urandom % 6];
    endtask

    task automatic fill_pairs(input int batch);
        fill_random();
        for (int l = 0; l < LANES; l++) begin
            int k = batch * LANES + l;
            if (k < 36) begin
                stim[0][l] = codes[k / 6];
                stim[1][l] = codes[k % 6];
            end
        end
    endtask

    task automatic fill_const(input logic [2:0] a, input logic [2:0] b);
        fill_random();
        for (int l = 0; l < LANES; l++) begin stim[0][l] = a; stim[1][l] = b; end
    endtask

    // Monitor: pops the oldest expected result whenever a result is valid.
    always @(negedge clk) begin
        if (!rst && out_vld) begin
            if (exp_q.size() == 0) begin
                check(0, "R7 unexpected valid", {127'd0, out_vld}, 128'd0);
            end else begin
                exp_t  e;
                exp_t  a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a.fin = res_fin; a.ini = res_ini; a.hz = res_hz; a.err = out_err;
                check(a == e, t, 128'(a), 128'(e));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [4:0] two_in [6] = '{5'd2, 5'd5, 5'd8, 5'd11, 5'd14, 5'd15};
        string      two_tag [6] = '{"R2 R10 AND2 pairs", "R5 NAND2 pairs", "R3 R10 OR2 pairs",
                                    "R5 NOR2 pairs", "R4 XOR2 pairs", "R5 XNOR2 pairs"};
        repeat (3) @(negedge clk);
        // R9: reset state
        check(out_vld == 0 && out_err == 0, "R9 reset flags", {126'd0, out_vld, out_err}, 128'd0);
        check(res_fin == 0 && res_ini == 0 && res_hz == 0, "R9 reset planes",
              128'({res_hz, res_ini, res_fin}), 128'd0);
        rst = 1'b0;

        // R1: named results
        fill_const(3'b101, 3'b110); apply(5'd2,  "R1 R AND F = P", 1, 3'b100);
        fill_const(3'b101, 3'b110); apply(5'd8,  "R1 R OR F = N",  1, 3'b111);
        fill_const(3'b101, 3'b101); apply(5'd14, "R1 R XOR R = P", 1, 3'b100);
        fill_const(3'b011, 3'b101); apply(5'd14, "R1 1 XOR R = F", 1, 3'b110);
        fill_const(3'b100, 3'b000); apply(5'd1,  "R1 R5 NOT P = N", 1, 3'b111);

        // R2 R3 R4 R5 R10: all 36 pairs on two-operand gates, spare slots random (R6)
        for (int g = 0; g < 6; g++)
            for (int b = 0; b < 2; b++) begin
                fill_pairs(b);
                apply(two_in[g], two_tag[g], 0, 3'b000);
            end

        // R5: buffer and inverter over all six codes
        fill_pairs(0); for (int l = 0; l < LANES; l++) stim[0][l] = codes[l % 6];
        apply(5'd0, "R5 BUF", 0, 3'b000);
        apply(5'd1, "R5 INV", 0, 3'b000);

        // R6: three- and four-operand gates, random vectors
        for (int opc = 3; opc <= 13; opc++) begin
            if (opc == 5 || opc == 8 || opc == 11) continue;
            for (int r = 0; r < 10; r++) begin
                fill_random();
                apply(5'(opc), "R6 wide gate random", 0, 3'b000);
            end
        end

        // R6: unused slots hold controlling values and must not matter
        fill_const(3'b101, 3'b011);
        for (int l = 0; l < LANES; l++) begin stim[2][l] = 3'b000; stim[3][l] = 3'b000; end
        apply(5'd2, "R6 AND2 ignores static 0 in slots 2,3", 1, 3'b101);
        for (int l = 0; l < LANES; l++) begin stim[1][l] = 3'b000; stim[2][l] = 3'b011; end
        apply(5'd8, "R6 OR2 ignores static 1 in slot 2", 1, 3'b101);

        // R8: unknown opcodes
        fill_random(); apply(5'd16, "R8 opcode 16", 0, 3'b000);
        fill_random(); apply(5'd31, "R8 opcode 31", 0, 3'b000);
        fill_random(); apply(5'd23, "R8 opcode 23", 0, 3'b000);

        // R7: gap between results, then back-to-back
        idle();
        fill_random(); apply(5'd10, "R7 after gap", 0, 3'b000);
        fill_const(3'b100, 3'b000); apply(5'd1, "R7 R5 back-to-back INV", 1, 3'b111);
        idle();
        idle();
        check(out_vld == 0, "R7 valid drops when idle", {127'd0, out_vld}, 128'd0);
        check(exp_q.size() == 0, "R7 all results delivered", 128'(exp_q.size()), 128'd0);

        // R9: reset clears a nonzero result
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(out_vld == 0 && out_err == 0 && res_fin == 0 && res_ini == 0 && res_hz == 0,
              "R9 reset clears result", 128'({out_vld, out_err, res_hz, res_ini, res_fin}), 128'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule